// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block sits in front of an on-chip nonvolatile byte array. The array is split into pages. The host sees an asynchronous-SRAM-style port with three active-low strobes: chip enable, output enable and write enable. All strobes are sampled on the system clock.

A write starts a load period. Later writes to the same page are gathered into a page buffer, and a per-byte valid mask records which offsets were touched. Offsets may arrive in any order, and an offset may be rewritten. The load period closes when no new byte arrives within a byte-load window. A timed programming period then copies only the marked bytes into the array.

While programming is in progress, the block is busy. Writes are ignored, and reads return a status pattern instead of array data, so that software can poll for completion.

All timings are cycle-count parameters:
- `BLC_CYC` is the byte-load window.
- `PROG_CYC` is the programming period.

The page size is `2**PAGE_W` bytes. The upper `ADDR_W-PAGE_W` address bits select the page.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy`, `pageError` and `rdData` are all 0.
- R2: In the cycle after an edge that sees `ceN`=0, `oeN`=0, `weN`=1 while not busy, `rdData` holds the array byte at `addr`. In any cycle without such a read, `rdData` is 0.
- R3: A write pulse is the interval in which both `ceN` and `weN` are 0. A pulse starts a write only if `oeN` is 1 when it begins. The address is taken at the pulse start, and the data is taken in the first cycle after the pulse ends.
- R4: The low `PAGE_W` address bits select a byte within the page. Bytes may be loaded in any order, and a later write to the same offset replaces the earlier one. After programming, only the offsets loaded in that period have changed in the array.
- R5: A byte that ends within `BLC_CYC` cycles of the previous accepted byte restarts the window. If the window expires, `busy` rises exactly `BLC_CYC` cycles after the last accepted byte.
- R6: A write pulse whose page bits differ from the page of the load period's first byte is ignored and sets `pageError`. The flag stays set until the first byte of the next load period is accepted.
- R7: `busy` stays high for exactly `PROG_CYC` cycles (with `PROG_CYC` > `2**PAGE_W`). Writes that begin while `busy` is high are ignored. The valid mask is empty when `busy` falls, so the next load period commits none of the earlier offsets.
- R8: A read while `busy` is high returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 flips between successive read accesses. Bits 5..0 equal bits 5..0 of the last accepted byte.
- R9: A load that touches all `2**PAGE_W` offsets of a page commits every one of them in a single programming period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits are the page, lower `PAGE_W` bits are the offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data or status byte; 0 when not reading |
| busy | output | 1 | Programming period in progress |
| pageError | output | 1 | Sticky flag for an ignored write to another page |

## Verification
The bench builds the block with the following values:
- `ADDR_W`=6 and `PAGE_W`=4, giving four 16-byte pages.
- `BLC_CYC`=12 and `PROG_CYC`=40.

With a 16-byte page, a complete page load and a check that neighbouring offsets are untouched take a few dozen writes. The short window and programming period let the bench measure the exact `busy` rise and duration. They also let it poll the status byte several times within one programming period, and push a late byte into the busy interval.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwcState_e;

  // Strobes from control to datapath, all single-cycle qualified.
  typedef struct packed {
    logic latchAddr;    // pulse start: capture address
    logic firstByte;    // first byte of a load period accepted
    logic storeByte;    // further byte on the same page accepted
    logic commitStart;  // window expired: rewind commit walker
    logic commitStep;   // walk one offset into the array
    logic clearMask;    // programming finished: drop valid mask
    logic readNormal;   // array read
    logic readPoll;     // status read while programming
    logic pollStart;    // first cycle of a status read access
  } pwcStrobes_t;

endpackage

// File: rtl/pwc_control.sv
module pwc_control
  import pwc_pkg::*;
#(
  parameter int BLC_CYC  = 2000,
  parameter int PROG_CYC = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        pageMatch,
  input  logic        commitDone,
  output pwcStrobes_t ctl,
  output logic        busy,
  output logic        pageError
);

  localparam int LOAD_W = $clog2(BLC_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  pwcState_e         state;
  logic              prevStrobe;
  logic              prevRead;
  logic              armed;
  logic [LOAD_W-1:0] loadCnt;
  logic [PROG_W-1:0] progCnt;

  logic strobe;
  logic readAct;
  logic startEdge;
  logic endEdge;
  logic acceptAny;
  logic timeout;

  assign strobe    = !ceN && !weN;
  assign readAct   = !ceN && !oeN && weN;
  assign startEdge = strobe && !prevStrobe && oeN && (state != ST_PROG);
  assign endEdge   = !strobe && prevStrobe && armed;
  assign busy      = (state == ST_PROG);

  always_comb begin
    ctl             = '0;
    ctl.latchAddr   = startEdge;
    ctl.firstByte   = endEdge && (state == ST_IDLE);
    ctl.storeByte   = endEdge && (state == ST_LOAD) && pageMatch;
    ctl.commitStep  = (state == ST_PROG) && !commitDone;
    ctl.clearMask   = (state == ST_PROG) && (progCnt == '0) && commitDone;
    ctl.readNormal  = readAct && (state != ST_PROG);
    ctl.readPoll    = readAct && (state == ST_PROG);
    ctl.pollStart   = readAct && (state == ST_PROG) && !prevRead;
    acceptAny       = ctl.firstByte || ctl.storeByte;
    timeout         = (state == ST_LOAD) && (loadCnt == '0) && !ctl.storeByte;
    ctl.commitStart = timeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStrobe <= 1'b0;
      prevRead   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      prevStrobe <= strobe;
      prevRead   <= readAct;
      if (startEdge)   armed <= 1'b1;
      else if (!strobe) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadCnt <= '0;
      progCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl.firstByte) begin
            state   <= ST_LOAD;
            loadCnt <= LOAD_W'(BLC_CYC - 1);
          end
        end
        ST_LOAD: begin
          if (ctl.storeByte) begin
            loadCnt <= LOAD_W'(BLC_CYC - 1);
          end else if (timeout) begin
            state   <= ST_PROG;
            progCnt <= PROG_W'(PROG_CYC - 1);
          end else begin
            loadCnt <= loadCnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (progCnt != '0) progCnt <= progCnt - 1'b1;
          else if (commitDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageError <= 1'b0;
    else if (ctl.firstByte) pageError <= 1'b0;
    else if (endEdge && (state == ST_LOAD) && !pageMatch) pageError <= 1'b1;
  end

  // Error flag only drops when a new load period begins.
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pageError && !ctl.firstByte) |=> pageError);

  // No byte enters the buffer while programming.
  assert_no_store_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    acceptAny |-> !busy);

  // Programming only ends after the commit walk has finished.
  assert_commit_before_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(commitDone));

  // Window counter never exceeds its reload value.
  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> (loadCnt < LOAD_W'(BLC_CYC)));

  // A byte accepted in the load state keeps the block loading next cycle.
  assert_window_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeByte |=> (state == ST_LOAD));

endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwcStrobes_t       ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic              pageMatch,
  output logic              commitDone,
  output logic [7:0]        rdData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PNUM_W     = ADDR_W - PAGE_W;
  localparam int MEM_DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0]     addrLat;
  logic [PNUM_W-1:0]     pageReg;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            memArr [MEM_DEPTH];
  logic [PAGE_W-1:0]     commitIdx;
  logic [7:0]            lastByte;
  logic                  toggleQ;

  logic [PAGE_W-1:0] offset;
  logic              loadByte;

  assign offset    = addrLat[PAGE_W-1:0];
  assign pageMatch = (addrLat[ADDR_W-1:PAGE_W] == pageReg);
  assign loadByte  = ctl.firstByte || ctl.storeByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat  <= '0;
      pageReg  <= '0;
      lastByte <= '0;
    end else begin
      if (ctl.latchAddr) addrLat  <= addr;
      if (ctl.firstByte) pageReg  <= addrLat[ADDR_W-1:PAGE_W];
      if (loadByte)      lastByte <= wrData;
    end
  end

  // Page buffer: storage only, contents qualified by the mask.
  always_ff @(posedge clk) begin
    if (loadByte) pageBuf[offset] <= wrData;
  end

  // One valid flag per page offset.
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     validMask[i] <= 1'b0;
      else if (ctl.clearMask)                        validMask[i] <= 1'b0;
      else if (loadByte && (offset == PAGE_W'(i)))   validMask[i] <= 1'b1;
    end
  end

  // Commit walker: one offset per cycle through the page.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitIdx  <= '0;
      commitDone <= 1'b0;
    end else if (ctl.commitStart) begin
      commitIdx  <= '0;
      commitDone <= 1'b0;
    end else if (ctl.commitStep) begin
      commitIdx <= commitIdx + 1'b1;
      if (commitIdx == PAGE_W'(PAGE_BYTES - 1)) commitDone <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.commitStep && validMask[commitIdx])
      memArr[{pageReg, commitIdx}] <= pageBuf[commitIdx];
  end

  // Read port: array data, status byte, or zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      toggleQ <= 1'b0;
    end else begin
      if (ctl.pollStart) toggleQ <= !toggleQ;
      if (ctl.readPoll)        rdData <= {~lastByte[7], toggleQ, lastByte[5:0]};
      else if (ctl.readNormal) rdData <= memArr[addr];
      else                     rdData <= '0;
    end
  end

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearMask |=> (validMask == '0));

  assert_store_marks_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadByte |=> validMask[$past(offset)]);

  assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.readNormal || ctl.readPoll) |=> (rdData == 8'h00));

  assert_poll_bit7_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readPoll |=> (rdData[7] != lastByte[7]));

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 8,
  parameter int BLC_CYC  = 2000,
  parameter int PROG_CYC = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              pageError
);

  pwcStrobes_t ctl;
  logic        pageMatch;
  logic        commitDone;

  pwc_control #(.BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) u_control (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .commitDone(commitDone),
    .ctl(ctl), .busy(busy), .pageError(pageError)
  );

  pwc_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .wrData(wrData),
    .pageMatch(pageMatch), .commitDone(commitDone), .rdData(rdData)
  );

  // Reset values of the outputs.
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!busy && !pageError));

endmodule

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;

  localparam int ADDR_W   = 6;
  localparam int PAGE_W   = 4;
  localparam int BLC_CYC  = 12;
  localparam int PROG_CYC = 40;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]       wrData = '0;
  logic [7:0]       rdData;
  logic             busy, pageError;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
                    .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .busy(busy), .pageError(pageError)
  );

  // op: 0 write, 1 wait for programming, 2 read and compare
  localparam logic [17:0] VEC [12] = '{
    {2'd0, 8'h13, 8'hA5},
    {2'd0, 8'h11, 8'h3C},
    {2'd0, 8'h13, 8'h5A},
    {2'd0, 8'h1F, 8'h81},
    {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h13, 8'h5A},
    {2'd2, 8'h11, 8'h3C},
    {2'd2, 8'h1F, 8'h81},
    {2'd2, 8'h10, 8'h40},
    {2'd2, 8'h12, 8'h42},
    {2'd2, 8'h1E, 8'h4E},
    {2'd2, 8'h23, 8'h83}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a[ADDR_W-1:0]; wrData = d; ceN = 0; weN = 0; oeN = 1;
    @(negedge clk);
    @(negedge clk);
    ceN = 1; weN = 1;
    @(negedge clk);
  endtask

  task automatic readByte(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a[ADDR_W-1:0]; ceN = 0; oeN = 0; weN = 1;
    @(negedge clk);
    d = rdData;
    ceN = 1; oeN = 1;
  endtask

  // Waits for programming; optionally checks window and busy length.
  task automatic waitReady(input bit timed);
    int idle = 0;
    int held = 0;
    while (!busy && idle < 1000) begin @(negedge clk); if (!busy) idle++; end
    while (busy && held < 1000) begin @(negedge clk); held++; end
    if (timed) begin
      check("R5 window", 8'(idle), 8'(BLC_CYC - 1));
      check("R7 busy length", 8'(held), 8'(PROG_CYC));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    repeat (3) @(negedge clk);
    check("R1 busy", 8'(busy), 8'h00);
    check("R1 pageError", 8'(pageError), 8'h00);
    check("R1 rdData", rdData, 8'h00);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R9: full background pages 1 and 2
    for (int p = 1; p <= 2; p++) begin
      for (int i = 0; i < 16; i++) writeByte(8'(p * 16 + i), 8'(p * 64 + i));
      waitReady(p == 1);
    end
    for (int i = 0; i < 16; i++) begin
      readByte(8'(16 + i), r);
      check("R9 full page", r, 8'(64 + i));
    end
    @(negedge clk);
    check("R2 idle rdData", rdData, 8'h00);

    // R4 table: out-of-order, overwrite, untouched neighbours
    foreach (VEC[k]) begin
      case (VEC[k][17:16])
        2'd0: writeByte(VEC[k][15:8], VEC[k][7:0]);
        2'd1: waitReady(1'b1);
        default: begin
          readByte(VEC[k][15:8], r);
          check("R4 page load", r, VEC[k][7:0]);
        end
      endcase
    end

    // R7: mask cleared; single byte on page 2 leaves offsets 1,3,15
    writeByte(8'h2A, 8'hC3);
    waitReady(1'b0);
    readByte(8'h2A, r);  check("R7 single byte", r, 8'hC3);
    readByte(8'h21, r);  check("R7 mask cleared", r, 8'h81);
    readByte(8'h2F, r);  check("R7 mask cleared", r, 8'h8F);

    // R5/R7: late byte lands in busy interval and is ignored
    writeByte(8'h24, 8'h11);
    repeat (BLC_CYC + 3) @(negedge clk);
    check("R5 window expired", 8'(busy), 8'h01);
    writeByte(8'h10, 8'hEE);
    waitReady(1'b0);
    readByte(8'h24, r);  check("R5 first byte", r, 8'h11);
    readByte(8'h10, r);  check("R7 busy write ignored", r, 8'h40);

    // R3: address at pulse start, data at pulse end
    @(negedge clk);
    addr = 6'h18; wrData = 8'h11; ceN = 0; weN = 0; oeN = 1;
    @(negedge clk);
    addr = 6'h19; wrData = 8'h99;
    @(negedge clk);
    ceN = 1; weN = 1;
    @(negedge clk);
    waitReady(1'b0);
    readByte(8'h18, r);  check("R3 address latch", r, 8'h99);
    readByte(8'h19, r);  check("R3 other address", r, 8'h49);

    // R3: pulse starting with oeN low does not write
    @(negedge clk);
    addr = 6'h17; wrData = 8'h00; ceN = 0; oeN = 0; weN = 0;
    repeat (2) @(negedge clk);
    ceN = 1; weN = 1; oeN = 1;
    repeat (BLC_CYC + 4) @(negedge clk);
    check("R3 oe low no load", 8'(busy), 8'h00);
    readByte(8'h17, r);  check("R3 oe low no write", r, 8'h47);

    // R8: status reads while programming
    writeByte(8'h1A, 8'h96);
    while (!busy) @(negedge clk);
    readByte(8'h1A, r);
    readByte(8'h1A, r2);
    check("R8 poll bit7", {7'd0, r[7]}, 8'h00);
    check("R8 poll low bits", {2'd0, r[5:0]}, 8'h16);
    check("R8 toggle", {7'd0, r[6] ^ r2[6]}, 8'h01);
    waitReady(1'b0);
    readByte(8'h1A, r);  check("R8 true data after", r, 8'h96);

    // R6: page mismatch ignored, sticky, cleared by next load
    writeByte(8'h22, 8'h55);
    writeByte(8'h15, 8'h77);
    check("R6 error set", 8'(pageError), 8'h01);
    writeByte(8'h26, 8'h66);
    waitReady(1'b0);
    check("R6 error sticky", 8'(pageError), 8'h01);
    readByte(8'h15, r);  check("R6 mismatch ignored", r, 8'h45);
    readByte(8'h26, r);  check("R6 same page kept", r, 8'h66);
    writeByte(8'h30, 8'h01);
    check("R6 error cleared", 8'(pageError), 8'h00);
    waitReady(1'b0);

    // R2: ceN high with oeN low gives no data
    @(negedge clk);
    addr = 6'h30; ceN = 1; oeN = 0;
    @(negedge clk);
    check("R2 no chip enable", rdData, 8'h00);
    oeN = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule